// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. On each clock edge it takes one operation code, two 8-bit operands and a bit selector. It registers an 8-bit result and a write-enable for that result, and it updates an 8-bit status register that it holds internally. The carry-in for the carry-chained operations and the bit used by bit-load both come from that held status. So a multibyte add, subtract or compare is a sequence of single-byte operations on consecutive cycles.

The status register is exposed as `status_o`. Its bit order from MSB to LSB is: interrupt enable (bit 7), bit-copy store T (bit 6), half carry H (bit 5), sign S (bit 4), overflow V (bit 3), negative N (bit 2), zero Z (bit 1), carry C (bit 0). Two pulse inputs from an external interrupt controller act on the interrupt-enable bit: one marks that an interrupt was taken and the other marks a return from the handler. Instruction fetch and the register file are outside this block.

Every result, write-enable and flag change appears on the outputs at the first rising edge after the inputs are presented.

Top module: `alu8_status`

## Requirements
- R1: While `rst_n` is low, `result_o`, `wen_o` and `status_o` are all zero.
- R2: For every operation that updates flags, N equals bit 7 of the result and Z is 1 exactly when the result is zero. The exceptions to the Z rule are those in R5. S equals N xor V in every cycle.
- R3: ADD (op 1) and ADC (op 2, which adds C as a carry-in) write a+b(+C). C is the carry out of bit 7, H is the carry out of bit 3, and V flags signed overflow.
- R4: SUB (op 3), SBC (op 4, which subtracts C as well) and NEG (op 9, which computes 0-a) write the difference. C is 1 exactly when the unsigned minuend is less than the subtrahend plus the borrow-in. H is the matching borrow from bit 4. V flags signed overflow.
- R5: SBC (op 4) and CPC (op 6) clear Z on a nonzero result and leave Z unchanged on a zero result. A chain of byte compares therefore leaves Z=1 only if every byte matched.
- R6: CP (op 5) and CPC (op 6) set C, H, V, N, Z and S as subtraction does, but `wen_o` is 0.
- R7: INC (op 7) and DEC (op 8) leave C and H unchanged. V is 1 only for the 0x7F-to-0x80 case of INC and the 0x80-to-0x7F case of DEC.
- R8: AND (op 10), OR (op 11), XOR (op 12) and CLR (op 14, which writes 0x00) force V to 0 and leave C and H unchanged. COM (op 13, which writes ~a) sets C to 1, sets V to 0 and leaves H unchanged.
- R9: SER (op 15) writes 0xFF and leaves every flag unchanged.
- R10: LSL (op 16) writes a shifted left by one with a 0 in bit 0. C is old a[7], H is old a[3], and V equals N xor C.
- R11: BST (op 17) copies a[`bsel_i`] into T, leaves the other flags unchanged and has `wen_o`=0. BLD (op 18) writes a with bit `bsel_i` replaced by T and leaves the flags unchanged.
- R12: `irq_take_i` clears the interrupt-enable bit and `irq_ret_i` sets it. If both are high in the same cycle, the clear wins. The bit is otherwise unchanged.
- R13: NOP (op 0) and codes above 18 leave the status unchanged and give `wen_o`=0. All outputs are registered and change one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand |
| bsel_i | input | 3 | Bit index for BST and BLD |
| irq_take_i | input | 1 | Interrupt-taken pulse |
| irq_ret_i | input | 1 | Return-from-interrupt pulse |
| result_o | output | 8 | Registered result |
| wen_o | output | 1 | Registered result write-enable |
| status_o | output | 8 | Status register {I,T,H,S,V,N,Z,C} |

## Verification
The status register feeds back into the next operation through the carry-in, the sticky Z and T. A corrupted flag therefore shows up on `status_o` in the cycle after it is written, and it also spreads into the next carry-chained result one cycle later. The bench keeps its own model of the status register and compares the whole 8-bit status every cycle. A flag that drifts is caught in the cycle it first differs, not just when a later operation happens to use it. Directed sequences cover the edges: nibble and byte carries, 0x7F and 0x80 overflow, and two-byte compare chains with and without a match.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 5;
    localparam int SEL_W  = $clog2(DATA_W);

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 5'd0,
        OP_ADD = 5'd1,
        OP_ADC = 5'd2,
        OP_SUB = 5'd3,
        OP_SBC = 5'd4,
        OP_CP  = 5'd5,
        OP_CPC = 5'd6,
        OP_INC = 5'd7,
        OP_DEC = 5'd8,
        OP_NEG = 5'd9,
        OP_AND = 5'd10,
        OP_OR  = 5'd11,
        OP_XOR = 5'd12,
        OP_COM = 5'd13,
        OP_CLR = 5'd14,
        OP_SER = 5'd15,
        OP_LSL = 5'd16,
        OP_BST = 5'd17,
        OP_BLD = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic ie;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_o,
    output logic             h_o,
    output logic             v_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] y_eff;
    logic             ci_eff;
    logic [WIDTH:0]   full;
    logic [HALF:0]    low;

    always_comb begin
        y_eff  = sub_i ? ~y_i : y_i;
        ci_eff = sub_i ? ~cin_i : cin_i;
        full   = {1'b0, x_i} + {1'b0, y_eff} + {{WIDTH{1'b0}}, ci_eff};
        low    = {1'b0, x_i[HALF-1:0]} + {1'b0, y_eff[HALF-1:0]} + {{HALF{1'b0}}, ci_eff};
        sum_o  = full[WIDTH-1:0];
        c_o    = sub_i ? ~full[WIDTH] : full[WIDTH];
        h_o    = sub_i ? ~low[HALF] : low[HALF];
        v_o    = (x_i[WIDTH-1] == y_eff[WIDTH-1]) && (full[WIDTH-1] != x_i[WIDTH-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int SELW  = SEL_W
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic             t_i,
    output logic [WIDTH-1:0] res_o,
    output logic             bit_o
);
    logic [WIDTH-1:0] bld_val;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bld
            assign bld_val[g] = (sel_i == SELW'(g)) ? t_i : a_i[g];
        end
    endgenerate

    assign bit_o = a_i[sel_i];

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~a_i;
            OP_CLR:  res_o = '0;
            OP_SER:  res_o = '1;
            OP_LSL:  res_o = {a_i[WIDTH-2:0], 1'b0};
            OP_BLD:  res_o = bld_val;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_i,
    input  logic [7:0]   a_i,
    input  logic [7:0]   b_i,
    input  logic [2:0]   bsel_i,
    input  logic         irq_take_i,
    input  logic         irq_ret_i,
    output logic [7:0]   result_o,
    output logic         wen_o,
    output logic [7:0]   status_o
);
    localparam int MSB  = DATA_W - 1;
    localparam int HBIT = DATA_W / 2 - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wen;
        sreg_t             st;
    } state_t;

    state_t  st_d, st_q;
    alu_op_e op;

    logic [DATA_W-1:0] as_x, as_y, as_sum, lg_res;
    logic              as_cin, as_sub, as_c, as_h, as_v, lg_bit;

    assign op = alu_op_e'(op_i);

    always_comb begin
        as_x   = a_i;
        as_y   = b_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:         as_cin = st_q.st.c;
            OP_SUB, OP_CP:  as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = st_q.st.c;
            end
            OP_INC: as_y = DATA_W'(1);
            OP_DEC: begin
                as_y   = DATA_W'(1);
                as_sub = 1'b1;
            end
            OP_NEG: begin
                as_x   = '0;
                as_y   = a_i;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.WIDTH(DATA_W)) u_addsub (
        .x_i   (as_x),
        .y_i   (as_y),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .sum_o (as_sum),
        .c_o   (as_c),
        .h_o   (as_h),
        .v_o   (as_v)
    );

    alu8_logic #(.WIDTH(DATA_W), .SELW(SEL_W)) u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (bsel_i),
        .t_i   (st_q.st.t),
        .res_o (lg_res),
        .bit_o (lg_bit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = a_i;
        st_d.wen = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_NEG: begin
                st_d.res  = as_sum;
                st_d.wen  = 1'b1;
                st_d.st.c = as_c;
                st_d.st.h = as_h;
                st_d.st.v = as_v;
                st_d.st.n = as_sum[MSB];
                st_d.st.z = (as_sum == '0);
            end
            OP_SBC, OP_CPC, OP_CP: begin
                st_d.res  = as_sum;
                st_d.wen  = (op == OP_SBC);
                st_d.st.c = as_c;
                st_d.st.h = as_h;
                st_d.st.v = as_v;
                st_d.st.n = as_sum[MSB];
                st_d.st.z = (op == OP_CP) ? (as_sum == '0)
                                          : ((as_sum == '0) && st_q.st.z);
            end
            OP_INC, OP_DEC: begin
                st_d.res  = as_sum;
                st_d.wen  = 1'b1;
                st_d.st.v = as_v;
                st_d.st.n = as_sum[MSB];
                st_d.st.z = (as_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_CLR, OP_COM: begin
                st_d.res  = lg_res;
                st_d.wen  = 1'b1;
                st_d.st.v = 1'b0;
                st_d.st.n = lg_res[MSB];
                st_d.st.z = (lg_res == '0);
                if (op == OP_COM) st_d.st.c = 1'b1;
            end
            OP_LSL: begin
                st_d.res  = lg_res;
                st_d.wen  = 1'b1;
                st_d.st.c = a_i[MSB];
                st_d.st.h = a_i[HBIT];
                st_d.st.n = lg_res[MSB];
                st_d.st.z = (lg_res == '0);
                st_d.st.v = lg_res[MSB] ^ a_i[MSB];
            end
            OP_SER, OP_BLD: begin
                st_d.res = lg_res;
                st_d.wen = 1'b1;
            end
            OP_BST: st_d.st.t = lg_bit;
            default: ;
        endcase
        st_d.st.s = st_d.st.n ^ st_d.st.v;
        if (irq_take_i)     st_d.st.ie = 1'b0;
        else if (irq_ret_i) st_d.st.ie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign wen_o    = st_q.wen;
    assign status_o = st_q.st;

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.st.s == (st_q.st.n ^ st_q.st.v)); // R2
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CP || op == OP_CPC) |=> !wen_o); // R6
    AST_STICKY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_SBC || op == OP_CPC) && !st_q.st.z && !irq_take_i) |=> !status_o[1]); // R5
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC || op == OP_DEC) |=> status_o[0] == $past(status_o[0])); // R7
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_i |=> !status_o[7]); // R12
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret_i && !irq_take_i) |=> status_o[7]); // R12
    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP && !irq_take_i && !irq_ret_i) |=> $stable(status_o) && !wen_o); // R13
endmodule

// File: tb/alu8_status_bench.sv
module alu8_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] op;
    logic [7:0] a, b;
    logic [2:0] bsel;
    logic       take, ret;
    logic [7:0] result;
    logic       wen;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    logic [7:0] mst;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_status u_alu8_status (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .bsel_i(bsel),
        .irq_take_i(take), .irq_ret_i(ret),
        .result_o(result), .wen_o(wen), .status_o(status)
    );

    // model: returns {wen, result, status}
    function automatic logic [16:0] model(input logic [4:0] o, input logic [7:0] x,
            input logic [7:0] y, input logic [2:0] s, input logic [7:0] st,
            input logic tk, input logic rt);
        logic [7:0] r = x;
        logic w = 1'b0;
        logic [7:0] f = st;
        logic [8:0] t9;
        int ci;
        logic zr;
        ci = 0;
        case (o)
            1, 2: begin
                ci = (o == 2) ? int'(st[0]) : 0;
                t9 = 9'(int'(x) + int'(y) + ci);
                r = t9[7:0]; w = 1;
                f[0] = t9[8];
                f[5] = (int'(x[3:0]) + int'(y[3:0]) + ci) > 15;
                f[3] = (x[7] == y[7]) && (r[7] != x[7]);
                f[2] = r[7]; f[1] = (r == 0);
            end
            3, 4, 5, 6, 9: begin
                logic [7:0] mx, my;
                mx = (o == 9) ? 8'd0 : x;
                my = (o == 9) ? x : y;
                ci = (o == 4 || o == 6) ? int'(st[0]) : 0;
                r = 8'(int'(mx) - int'(my) - ci);
                w = (o == 3 || o == 4 || o == 9);
                f[0] = int'(mx) < int'(my) + ci;
                f[5] = int'(mx[3:0]) < int'(my[3:0]) + ci;
                f[3] = (mx[7] != my[7]) && (r[7] != mx[7]);
                f[2] = r[7];
                zr = (r == 0);
                f[1] = (o == 4 || o == 6) ? (zr && st[1]) : zr;
            end
            7: begin r = x + 8'd1; w = 1; f[3] = (x == 8'h7F); f[2] = r[7]; f[1] = (r == 0); end
            8: begin r = x - 8'd1; w = 1; f[3] = (x == 8'h80); f[2] = r[7]; f[1] = (r == 0); end
            10, 11, 12, 13, 14: begin
                r = (o == 10) ? (x & y) : (o == 11) ? (x | y) : (o == 12) ? (x ^ y) :
                    (o == 13) ? ~x : 8'h00;
                w = 1; f[3] = 0; f[2] = r[7]; f[1] = (r == 0);
                if (o == 13) f[0] = 1;
            end
            15: begin r = 8'hFF; w = 1; end
            16: begin
                r = {x[6:0], 1'b0}; w = 1;
                f[0] = x[7]; f[5] = x[3]; f[2] = r[7]; f[1] = (r == 0);
                f[3] = r[7] ^ x[7];
            end
            17: f[6] = x[s];
            18: begin r = x; r[s] = st[6]; w = 1; end
            default: ;
        endcase
        f[4] = f[2] ^ f[3];
        if (tk) f[7] = 0; else if (rt) f[7] = 1;
        return {w, r, f};
    endfunction

    function automatic string tag_of(input logic [4:0] o, input logic tk, input logic rt);
        if (tk || rt) return "R12";
        case (o)
            1, 2: return "R3";
            3, 9: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R5";
            7, 8: return "R7";
            10, 11, 12, 13, 14: return "R8";
            15: return "R9";
            16: return "R10";
            17, 18: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic step(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic [2:0] s, input logic tk, input logic rt);
        logic [16:0] exp;
        string tg;
        op = o; a = x; b = y; bsel = s; take = tk; ret = rt;
        exp = model(o, x, y, s, mst, tk, rt);
        tg = tag_of(o, tk, rt);
        @(posedge clk);
        #1;
        checks++;
        if (wen !== exp[16] || status !== exp[7:0] || (exp[16] && result !== exp[15:8])) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h: got wen=%b res=%h st=%b, expected wen=%b res=%h st=%b",
                     tg, o, x, y, wen, result, status, exp[16], exp[15:8], exp[7:0]);
        end
        // R2: S must always equal N xor V
        checks++;
        if (status[4] !== (status[2] ^ status[3])) begin
            errors++;
            $display("FAIL R2 sign rule: got S=%b, expected %b", status[4], status[2] ^ status[3]);
        end
        mst = exp[7:0];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        rst_n = 1'b0; op = 0; a = 0; b = 0; bsel = 0; take = 0; ret = 0;
        mst = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (result !== 8'h00 || wen !== 1'b0 || status !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset: got res=%h wen=%b st=%h, expected 00 0 00", result, wen, status);
        end
        rst_n = 1'b1;

        // R3 carries and overflow
        step(1, 8'h0F, 8'h01, 0, 0, 0);
        step(1, 8'h7F, 8'h01, 0, 0, 0);
        step(1, 8'hFF, 8'h01, 0, 0, 0);
        step(2, 8'h00, 8'h00, 0, 0, 0);
        // R4 borrow and NEG
        step(3, 8'h00, 8'h01, 0, 0, 0);
        step(4, 8'h10, 8'h0F, 0, 0, 0);
        step(9, 8'h80, 8'h00, 0, 0, 0);
        step(9, 8'h00, 8'h00, 0, 0, 0);
        // R5 / R6 two-byte compares: equal then differing low byte
        step(5, 8'h34, 8'h34, 0, 0, 0);
        step(6, 8'h12, 8'h12, 0, 0, 0);
        checks++;
        if (status[1] !== 1'b1) begin
            errors++; $display("FAIL R5 equal chain: got Z=%b, expected 1", status[1]);
        end
        step(5, 8'h35, 8'h34, 0, 0, 0);
        step(6, 8'h12, 8'h12, 0, 0, 0);
        checks++;
        if (status[1] !== 1'b0) begin
            errors++; $display("FAIL R5 unequal chain: got Z=%b, expected 0", status[1]);
        end
        // R7 overflow corners
        step(7, 8'h7F, 0, 0, 0, 0);
        step(8, 8'h80, 0, 0, 0, 0);
        step(7, 8'hFF, 0, 0, 0, 0);
        // R8, R9, R10
        step(13, 8'h5A, 0, 0, 0, 0);
        step(14, 8'hAA, 0, 0, 0, 0);
        step(15, 8'h00, 0, 0, 0, 0);
        step(16, 8'h88, 0, 0, 0, 0);
        step(16, 8'h40, 0, 0, 0, 0);
        // R11 bit store then load
        step(17, 8'h20, 0, 3'd5, 0, 0);
        step(18, 8'h00, 0, 3'd2, 0, 0);
        step(17, 8'hDF, 0, 3'd5, 0, 0);
        step(18, 8'hFF, 0, 3'd7, 0, 0);
        // R12 interrupt enable
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 1);
        // R13 unused codes
        step(5'd25, 8'h11, 8'h22, 0, 0, 0);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [4:0] ro;
            ro = 5'($urandom_range(0, 19));
            step(ro, 8'($urandom), 8'($urandom), 3'($urandom),
                 ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule